// File: doc/BRIEF.md
# NAND Controller Configuration Register File with Write Lock

This block holds the static setup of a NAND flash controller: a four-bit interface configuration word, a packed timing word and a chip-enable control bit. The surrounding controller reads the decoded bits directly from the outputs. The NAND signalling itself lives elsewhere.

A bus-side write port addresses five registers by a three-bit select. The configuration and timing registers are protected. Software must first write a 16-bit unlock key to the key register, and the very next protected write is then accepted. That write engages the lock again, so every protected write needs a fresh key. A write to a protected register while the lock is engaged changes nothing and raises a one-cycle fault pulse. Writing the reset code to the command register clears every register. A combinational read port returns the stored values and the state of the lock.

Top module: `nandcfg_regfile`

## Requirements
- R1: While the synchronous active-high `rst` is high, every stored register clears to zero at the clock edge and the lock engages. The outputs are zero in the cycle after that edge.
- R2: A write of `wr_data[15:0]` = 0xA25E to select 3 (key) arms the unlock. A key write of any other value leaves the protected registers locked, and it also drops an earlier unlock.
- R3: When armed, one write to select 1 (configuration) or select 2 (timing) updates that register at the next edge and re-engages the lock. A second protected write without a new key is ignored.
- R4: A protected write made while locked leaves configuration and timing unchanged. It drives `wp_fault` high for exactly the one cycle after that write's clock edge.
- R5: Configuration field positions: bit 3 drives `cfg_wprot` (write protection), bit 2 drives `cfg_large_blk` (large-block device), bit 1 drives `cfg_long_addr` (five-byte addressing) and bit 0 drives `cfg_wide_bus` (16-bit bus).
- R6: The timing register keeps `wr_data[26:0]` and drops the higher bits. Its value appears on `timing_word`.
- R7: Select 4 (chip-enable control) needs no key. Its bit 0 is stored and drives `ce_auto`, where 1 means the controller drives chip enable itself.
- R8: A write to select 0 (command) or select 4 made between the key and the protected write cancels the unlock. Writes to select codes 5 to 7 are ignored and do not cancel it.
- R9: A write of `wr_data[7:0]` = 0xFF to select 0 clears configuration, timing and chip-enable control and engages the lock. Any other command code leaves the stored values unchanged.
- R10: `rd_data` is combinational in `rd_sel`. Select 1 gives the configuration in bits 3:0, select 2 gives the timing word, select 3 gives 1 in bit 0 while armed, and select 4 gives the chip-enable bit in bit 0. Select 0 and selects 5 to 7 read zero, and all unused bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for read-back |
| rd_data | output | 32 | Read-back data, combinational |
| cfg_wprot | output | 1 | Write protection enable |
| cfg_large_blk | output | 1 | Large-block device select |
| cfg_long_addr | output | 1 | Five-byte address select |
| cfg_wide_bus | output | 1 | 16-bit bus select |
| timing_word | output | 27 | Stored timing word |
| ce_auto | output | 1 | Chip enable driven by the controller |
| wp_fault | output | 1 | One-cycle pulse on a write refused by the lock |

## Verification
The lock state is internal, and it shows at the ports in two ways. It appears directly through read-back select 3 in the cycle after any write. It also appears indirectly, because a protected write is either taken or refused, and a refusal pulses `wp_fault` one cycle after the write. If the arm flag stays set too long, a second protected write is accepted when it should be refused. If the flag is cleared too early, a write is refused with a fault right after a valid key. In both cases the error shows within one cycle of the next protected write. A wrong configuration bit position or a timing mask error shows on the decoded outputs one cycle after the accepted write.

// File: rtl/nandcfg_pkg.sv
package nandcfg_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD = 3'd0,
        SEL_CFG = 3'd1,
        SEL_TIM = 3'd2,
        SEL_KEY = 3'd3,
        SEL_CEC = 3'd4
    } reg_sel_e;

    // Field order matters: the packed layout puts wprot at bit 3, wide_bus at bit 0.
    typedef struct packed {
        logic wprot;
        logic large_blk;
        logic long_addr;
        logic wide_bus;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef struct packed {
        logic hit_cmd;
        logic hit_cfg;
        logic hit_tim;
        logic hit_key;
        logic hit_cec;
        logic key_ok;
        logic soft_rst;
    } wr_dec_t;

    function automatic logic is_protected(input wr_dec_t d);
        return d.hit_cfg | d.hit_tim;
    endfunction

    function automatic logic cancels_unlock(input wr_dec_t d);
        return d.hit_cmd | d.hit_cec | d.hit_cfg | d.hit_tim;
    endfunction

endpackage

// File: rtl/nandcfg_decode.sv
module nandcfg_decode
    import nandcfg_pkg::*;
#(
    parameter int              KEY_W      = 16,
    parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hA25E,
    parameter int              CMD_W      = 8,
    parameter logic [CMD_W-1:0] RESET_CODE = 8'hFF
) (
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [KEY_W-1:0] key_field,
    input  logic [CMD_W-1:0] cmd_field,
    output wr_dec_t          dec
);

    always_comb begin
        dec = '0;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_CMD: begin
                    dec.hit_cmd  = 1'b1;
                    dec.soft_rst = (cmd_field == RESET_CODE);
                end
                SEL_CFG: dec.hit_cfg = 1'b1;
                SEL_TIM: dec.hit_tim = 1'b1;
                SEL_KEY: begin
                    dec.hit_key = 1'b1;
                    dec.key_ok  = (key_field == UNLOCK_KEY);
                end
                SEL_CEC: dec.hit_cec = 1'b1;
                default: dec = '0;
            endcase
        end
    end

endmodule

// File: rtl/nandcfg_lock.sv
module nandcfg_lock
    import nandcfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_dec_t dec,
    output logic    armed,
    output logic    grant,
    output logic    fault
);

    logic prot_hit;
    logic drop_arm;
    logic soft_unused;

    assign prot_hit    = is_protected(dec);
    assign drop_arm    = cancels_unlock(dec);
    assign grant       = prot_hit & armed;
    assign soft_unused = dec.soft_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            fault <= 1'b0;
        end else begin
            fault <= prot_hit & ~armed;
            if (dec.hit_key) begin
                armed <= dec.key_ok;
            end else if (drop_arm) begin
                armed <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/nandcfg_regs.sv
module nandcfg_regs
    import nandcfg_pkg::*;
#(
    parameter int TIM_W = 27
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_dec_t          dec,
    input  logic             grant,
    input  logic [TIM_W-1:0] wdata,
    output cfg_t             cfg_q,
    output logic [TIM_W-1:0] tim_q,
    output logic             cec_q
);

    logic dec_unused;
    assign dec_unused = dec.hit_cmd ^ dec.hit_key ^ dec.key_ok;

    always_ff @(posedge clk) begin
        if (rst || dec.soft_rst) begin
            cfg_q <= '0;
            tim_q <= '0;
            cec_q <= 1'b0;
        end else begin
            if (grant && dec.hit_cfg) begin
                cfg_q <= cfg_t'(wdata[CFG_W-1:0]);
            end
            if (grant && dec.hit_tim) begin
                tim_q <= wdata;
            end
            if (dec.hit_cec) begin
                cec_q <= wdata[0];
            end
        end
    end

endmodule

// File: rtl/nandcfg_rdmux.sv
module nandcfg_rdmux
    import nandcfg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TIM_W  = 27
) (
    input  logic [SEL_W-1:0]  rd_sel,
    input  cfg_t              cfg_q,
    input  logic [TIM_W-1:0]  tim_q,
    input  logic              armed,
    input  logic              cec_q,
    output logic [DATA_W-1:0] rd_data
);

    always_comb begin
        rd_data = '0;
        unique case (reg_sel_e'(rd_sel))
            SEL_CFG: rd_data = DATA_W'(cfg_q);
            SEL_TIM: rd_data = DATA_W'(tim_q);
            SEL_KEY: rd_data = DATA_W'(armed);
            SEL_CEC: rd_data = DATA_W'(cec_q);
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/nandcfg_regfile.sv
module nandcfg_regfile
    import nandcfg_pkg::*;
#(
    parameter int               DATA_W     = 32,
    parameter int               TIM_W      = 27,
    parameter int               KEY_W      = 16,
    parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hA25E,
    parameter int               CMD_W      = 8,
    parameter logic [CMD_W-1:0] RESET_CODE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              cfg_wprot,
    output logic              cfg_large_blk,
    output logic              cfg_long_addr,
    output logic              cfg_wide_bus,
    output logic [TIM_W-1:0]  timing_word,
    output logic              ce_auto,
    output logic              wp_fault
);

    wr_dec_t          dec;
    logic             armed;
    logic             grant;
    cfg_t             cfg_q;
    logic [TIM_W-1:0] tim_q;
    logic             cec_q;

    generate
        if (DATA_W > TIM_W) begin : g_spare
            logic spare_unused;
            assign spare_unused = ^wr_data[DATA_W-1:TIM_W];
        end
    endgenerate

    nandcfg_decode #(
        .KEY_W      (KEY_W),
        .UNLOCK_KEY (UNLOCK_KEY),
        .CMD_W      (CMD_W),
        .RESET_CODE (RESET_CODE)
    ) u_decode (
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .key_field (wr_data[KEY_W-1:0]),
        .cmd_field (wr_data[CMD_W-1:0]),
        .dec       (dec)
    );

    nandcfg_lock u_lock (
        .clk   (clk),
        .rst   (rst),
        .dec   (dec),
        .armed (armed),
        .grant (grant),
        .fault (wp_fault)
    );

    nandcfg_regs #(
        .TIM_W (TIM_W)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .dec   (dec),
        .grant (grant),
        .wdata (wr_data[TIM_W-1:0]),
        .cfg_q (cfg_q),
        .tim_q (tim_q),
        .cec_q (cec_q)
    );

    nandcfg_rdmux #(
        .DATA_W (DATA_W),
        .TIM_W  (TIM_W)
    ) u_rdmux (
        .rd_sel  (rd_sel),
        .cfg_q   (cfg_q),
        .tim_q   (tim_q),
        .armed   (armed),
        .cec_q   (cec_q),
        .rd_data (rd_data)
    );

    assign cfg_wprot     = cfg_q.wprot;
    assign cfg_large_blk = cfg_q.large_blk;
    assign cfg_long_addr = cfg_q.long_addr;
    assign cfg_wide_bus  = cfg_q.wide_bus;
    assign timing_word   = tim_q;
    assign ce_auto       = cec_q;

endmodule

// File: rtl/nandcfg_regfile_chk.sv
module nandcfg_regfile_chk
    import nandcfg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TIM_W  = 27
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              armed,
    input logic [3:0]        cfg,
    input logic [TIM_W-1:0]  timing,
    input logic              ce,
    input logic              fault
);

    logic prot_wr;
    assign prot_wr = wr_en && (wr_sel == SEL_CFG || wr_sel == SEL_TIM);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!armed && cfg == '0 && timing == '0 && !ce && !fault));

    p_key_arms_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_KEY && wr_data[15:0] == 16'hA25E) |=> armed);

    p_relock_r3: assert property (@(posedge clk) disable iff (rst)
        (prot_wr && armed) |=> !armed);

    p_locked_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (prot_wr && !armed) |=> ($stable(cfg) && $stable(timing) && fault));

    p_fault_cause_r4: assert property (@(posedge clk) disable iff (rst)
        fault |-> $past(prot_wr && !armed));

    p_cancel_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel == SEL_CMD || wr_sel == SEL_CEC)) |=> !armed);

    p_cmd_reset_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_CMD && wr_data[7:0] == 8'hFF)
            |=> (cfg == '0 && timing == '0 && !ce));

endmodule

bind nandcfg_regfile nandcfg_regfile_chk #(
    .DATA_W (DATA_W),
    .TIM_W  (TIM_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .armed   (armed),
    .cfg     ({cfg_wprot, cfg_large_blk, cfg_long_addr, cfg_wide_bus}),
    .timing  (timing_word),
    .ce      (ce_auto),
    .fault   (wp_fault)
);

// File: tb/sim_nandcfg_regfile.sv
module sim_nandcfg_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        cfg_wprot, cfg_large_blk, cfg_long_addr, cfg_wide_bus;
    logic [26:0] timing_word;
    logic        ce_auto;
    logic        wp_fault;

    int tests = 0;
    int fails = 0;
    bit live  = 1'b0;
    bit done  = 1'b0;

    // behavioural reference state
    logic [3:0]  m_cfg = '0;
    logic [26:0] m_tim = '0;
    logic        m_ce = 1'b0;
    logic        m_armed = 1'b0;
    logic        m_fault = 1'b0;

    always #10 clk = ~clk;

    nandcfg_regfile u0 (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .rd_sel        (rd_sel),
        .rd_data       (rd_data),
        .cfg_wprot     (cfg_wprot),
        .cfg_large_blk (cfg_large_blk),
        .cfg_long_addr (cfg_long_addr),
        .cfg_wide_bus  (cfg_wide_bus),
        .timing_word   (timing_word),
        .ce_auto       (ce_auto),
        .wp_fault      (wp_fault)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] cfg_out();
        return {cfg_wprot, cfg_large_blk, cfg_long_addr, cfg_wide_bus};
    endfunction

    // reference model, evaluated at each rising edge
    always @(posedge clk) begin
        live = 1'b1;
        if (rst) begin
            m_cfg = '0; m_tim = '0; m_ce = 1'b0; m_armed = 1'b0; m_fault = 1'b0;
        end else begin
            m_fault = wr_en && (wr_sel == 3'd1 || wr_sel == 3'd2) && !m_armed;
            if (wr_en) begin
                case (wr_sel)
                    3'd0: begin
                        m_armed = 1'b0;
                        if (wr_data[7:0] == 8'hFF) begin
                            m_cfg = '0; m_tim = '0; m_ce = 1'b0;
                        end
                    end
                    3'd1: if (m_armed) begin m_cfg = wr_data[3:0]; m_armed = 1'b0; end
                    3'd2: if (m_armed) begin m_tim = wr_data[26:0]; m_armed = 1'b0; end
                    3'd3: m_armed = (wr_data[15:0] == 16'hA25E);
                    3'd4: begin m_ce = wr_data[0]; m_armed = 1'b0; end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] s);
        case (s)
            3'd1: return {28'd0, m_cfg};
            3'd2: return {5'd0, m_tim};
            3'd3: return {31'd0, m_armed};
            3'd4: return {31'd0, m_ce};
            default: return 32'd0;
        endcase
    endfunction

    // per-clock comparison against the model; read select walks all codes
    always @(negedge clk) begin
        if (live && !done) begin
            check("R5 cfg", {28'd0, cfg_out()}, {28'd0, m_cfg});
            check("R6 timing", {5'd0, timing_word}, {5'd0, m_tim});
            check("R7 ce", {31'd0, ce_auto}, {31'd0, m_ce});
            check("R4 fault", {31'd0, wp_fault}, {31'd0, m_fault});
            check("R10 readback", rd_data, exp_rd(rd_sel));
            rd_sel <= rd_sel + 3'd1;
        end
    end

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 cfg reset", {28'd0, cfg_out()}, 32'd0);
        check("R1 timing reset", {5'd0, timing_word}, 32'd0);
        check("R1 ce reset", {31'd0, ce_auto}, 32'd0);

        // R4: locked write refused, fault pulse for one cycle
        wr(3'd1, 32'hF);
        check("R4 locked cfg unchanged", {28'd0, cfg_out()}, 32'd0);
        check("R4 fault high", {31'd0, wp_fault}, 32'd1);
        @(negedge clk);
        check("R4 fault one cycle", {31'd0, wp_fault}, 32'd0);

        // R2: wrong key does not unlock
        wr(3'd3, 32'h1234);
        wr(3'd1, 32'hF);
        check("R2 wrong key ignored", {28'd0, cfg_out()}, 32'd0);

        // R2/R5: right key, cfg 1010
        wr(3'd3, 32'hA25E);
        wr(3'd1, 32'hA);
        check("R5 wprot bit3", {31'd0, cfg_wprot}, 32'd1);
        check("R5 large bit2", {31'd0, cfg_large_blk}, 32'd0);
        check("R5 long addr bit1", {31'd0, cfg_long_addr}, 32'd1);
        check("R5 wide bit0", {31'd0, cfg_wide_bus}, 32'd0);

        // R3: relock after one write
        wr(3'd1, 32'h5);
        check("R3 second write ignored", {28'd0, cfg_out()}, 32'hA);
        check("R3 fault on relocked write", {31'd0, wp_fault}, 32'd1);

        // R6: timing mask
        wr(3'd3, 32'hA25E);
        wr(3'd2, 32'hFFFF_FFFF);
        check("R6 timing 27 bits", {5'd0, timing_word}, 32'h07FF_FFFF);

        // R7: ce without key
        wr(3'd4, 32'h1);
        check("R7 ce set", {31'd0, ce_auto}, 32'd1);

        // R8: ce write cancels unlock
        wr(3'd3, 32'hA25E);
        wr(3'd4, 32'h1);
        wr(3'd1, 32'h3);
        check("R8 cancel by ce", {28'd0, cfg_out()}, 32'hA);

        // R8/R9: non-reset command cancels and keeps values
        wr(3'd3, 32'hA25E);
        wr(3'd0, 32'h00);
        wr(3'd2, 32'h0);
        check("R8 cancel by cmd", {5'd0, timing_word}, 32'h07FF_FFFF);
        check("R9 other code keeps cfg", {28'd0, cfg_out()}, 32'hA);

        // R8: unused select does not cancel
        wr(3'd3, 32'hA25E);
        wr(3'd6, 32'hFFFF);
        wr(3'd1, 32'h6);
        check("R8 unused select no cancel", {28'd0, cfg_out()}, 32'h6);

        // R9: reset command
        wr(3'd3, 32'hA25E);
        wr(3'd0, 32'hFF);
        check("R9 cfg cleared", {28'd0, cfg_out()}, 32'd0);
        check("R9 timing cleared", {5'd0, timing_word}, 32'd0);
        check("R9 ce cleared", {31'd0, ce_auto}, 32'd0);
        wr(3'd1, 32'hF);
        check("R9 lock engaged", {28'd0, cfg_out()}, 32'd0);

        // R1: mid-run reset
        wr(3'd4, 32'h1);
        wr(3'd3, 32'hA25E);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 mid reset ce", {31'd0, ce_auto}, 32'd0);
        wr(3'd2, 32'h123);
        check("R1 lock after reset", {5'd0, timing_word}, 32'd0);

        // random traffic, compared by the model each clock (R2..R10)
        for (int i = 0; i < 400; i++) begin
            logic [2:0]  s;
            logic [31:0] d;
            s = 3'($urandom_range(0, 7));
            d = $urandom();
            if (s == 3'd3 && $urandom_range(0, 1) == 1) d[15:0] = 16'hA25E;
            if (s == 3'd0 && $urandom_range(0, 7) != 0) d[7:0] = 8'h00;
            if ($urandom_range(0, 2) == 0) begin
                wr(3'd3, 32'hA25E);
            end
            wr(s, d);
        end
        repeat (8) @(negedge clk);
        finish_run();
    end

endmodule